// File: doc/BRIEF.md
# Dual-Clock Registered Bus Transceiver

This block connects a local datapath to a shared multi-drop bus through two independent register banks. The transmit bank captures local data on its own clock and presents it to the bus. Each bus bit has its own output enable: when the enable is high, the bit carries the registered value, and when it is low the bit is released (high impedance), so another agent may drive it. The receive bank samples the bus lines on a second, unrelated clock and presents the captured word on dedicated receiver outputs.

The two banks share nothing except an active-high clear. The clear zeroes both banks at once, without waiting for either clock. Because the receive bank samples the bus itself, it captures the block's own driven bits as readily as a remote driver's. A transmit load followed by a receive capture, with the enables high, therefore returns the local word as a loopback. The block has no synchroniser between the clocks. Whoever drives the bus must meet the receive clock's setup and hold window.

Top module: `dual_clk_bus_xcvr`

## Requirements
- R1: On each rising edge of `txclk_i` (with `clr_i` low), `dat_i` is loaded into the transmit register. Bus bit i always corresponds to data bit i and register bit i. The register does not change between rising edges of `txclk_i`.
- R2: On each rising edge of `rxclk_i` (with `clr_i` low), the value present on `bus_io` is loaded into the receive register, which drives `rcv_o`. `rcv_o` does not change between rising edges of `rxclk_i`.
- R3: While `oe_i[i]` is 1, `bus_io[i]` carries bit i of the transmit register.
- R4: While `oe_i[i]` is 0, the block does not drive `bus_io[i]` (high impedance). A value put on that bit by an external driver appears on the bus and is captured by the receive register.
- R5: The enables act per bit. In one word, enabled bits carry the transmit register and released bits carry the external driver's values.
- R6: While `clr_i` is 1, both the transmit and the receive registers are 0. The clear takes effect as soon as `clr_i` rises, with no clock edge.
- R7: After `clr_i` falls, each register stays 0 until the next rising edge of its own clock.
- R8: The enables are combinational. A change of `oe_i` drives or releases bus bits at once and leaves the transmit register contents unchanged.
- R9: With all enables high and no external driver, a transmit edge followed by a receive edge returns the transmit data on `rcv_o`.
- R10: The clocks are independent. A transmit edge alone leaves `rcv_o` unchanged, and a receive edge alone leaves the transmit register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| txclk_i | input | 1 | Transmit bank clock, rising edge |
| rxclk_i | input | 1 | Receive bank clock, rising edge |
| clr_i | input | 1 | Asynchronous active-high clear of both banks |
| dat_i | input | WIDTH | Local data loaded into the transmit bank |
| oe_i | input | WIDTH | Per-bit bus drive enable, 1 = drive, 0 = release |
| bus_io | inout | WIDTH | Shared bus lines |
| rcv_o | output | WIDTH | Receive bank contents |

## Verification
The assertions assume a single driver per bus bit. While a bit is enabled, no external agent drives it, so the sampled bus equals the transmit register on those bits. They also assume that `clr_i` never changes at the same instant as a clock edge, so the hold-after-clear checks see a settled register. The bench keeps to both rules. Its external driver is turned on only for bits whose enables are low, and every clock pulse and every clear transition is placed on a separate phase of the bench's reference clock. The bench also catches the block driving a released bit by putting the opposite value on that bit from outside and reading the bus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    parameter int unsigned XCVR_W_DEF = 5;

    typedef enum logic {
        PIN_RELEASE = 1'b0,
        PIN_DRIVE   = 1'b1
    } pin_mode_e;

    function automatic pin_mode_e pin_mode(input logic en);
        return en ? PIN_DRIVE : PIN_RELEASE;
    endfunction

endpackage

// File: rtl/xcvr_tx_bank.sv
module xcvr_tx_bank #(
    parameter int unsigned W = xcvr_pkg::XCVR_W_DEF
) (
    input  logic         clk_i,
    input  logic         clr_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) q_o <= '0;
        else       q_o <= d_i;
    end

    // R6: the bank is still zero when the clear is released
    always @(negedge clr_i) begin
        p_tx_clear_r6: assert (q_o == '0)
            else $error("transmit bank not cleared");
    end

    // R7: first edge after the clear still sees an empty bank
    p_tx_hold_r7: assert property (@(posedge clk_i) disable iff (clr_i)
        $past(clr_i) |-> (q_o == '0));

endmodule

// File: rtl/xcvr_rx_bank.sv
module xcvr_rx_bank #(
    parameter int unsigned W = xcvr_pkg::XCVR_W_DEF
) (
    input  logic         clk_i,
    input  logic         clr_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) q_o <= '0;
        else       q_o <= d_i;
    end

    // R6: the bank is still zero when the clear is released
    always @(negedge clr_i) begin
        p_rx_clear_r6: assert (q_o == '0)
            else $error("receive bank not cleared");
    end

    // R7: first edge after the clear still sees an empty bank
    p_rx_hold_r7: assert property (@(posedge clk_i) disable iff (clr_i)
        $past(clr_i) |-> (q_o == '0));

endmodule

// File: rtl/dual_clk_bus_xcvr.sv
module dual_clk_bus_xcvr #(
    parameter int unsigned WIDTH = xcvr_pkg::XCVR_W_DEF
) (
    input  logic             txclk_i,
    input  logic             rxclk_i,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] dat_i,
    input  logic [WIDTH-1:0] oe_i,
    inout  wire  [WIDTH-1:0] bus_io,
    output logic [WIDTH-1:0] rcv_o
);
    import xcvr_pkg::*;

    logic [WIDTH-1:0] tx_q;

    xcvr_tx_bank #(.W(WIDTH)) u_tx (
        .clk_i (txclk_i),
        .clr_i (clr_i),
        .d_i   (dat_i),
        .q_o   (tx_q)
    );

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            pin_mode_e mode;
            assign mode      = pin_mode(oe_i[i]);
            assign bus_io[i] = (mode == PIN_DRIVE) ? tx_q[i] : 1'bz;
        end
    endgenerate

    xcvr_rx_bank #(.W(WIDTH)) u_rx (
        .clk_i (rxclk_i),
        .clr_i (clr_i),
        .d_i   (bus_io),
        .q_o   (rcv_o)
    );

    // R3: every enabled bit seen by the receive bank matches the transmit bank
    p_drive_r3: assert property (@(posedge rxclk_i) disable iff (clr_i)
        (((bus_io ^ tx_q) & oe_i) == '0));

endmodule

// File: tb/tb_dual_clk_bus_xcvr.sv
`timescale 1ns/1ps
module tb_dual_clk_bus_xcvr;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         txclk = 1'b0;
    logic         rxclk = 1'b0;
    logic         clr = 1'b0;
    logic [W-1:0] dat = '0;
    logic [W-1:0] oe = '0;
    logic [W-1:0] ext_en = '0;
    logic [W-1:0] ext_val = '0;
    wire  [W-1:0] bus;
    logic [W-1:0] rcv;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz reference

    generate
        for (genvar i = 0; i < W; i++) begin : g_ext
            assign bus[i] = ext_en[i] ? ext_val[i] : 1'bz;
        end
    endgenerate

    dual_clk_bus_xcvr #(.WIDTH(W)) dut (
        .txclk_i (txclk),
        .rxclk_i (rxclk),
        .clr_i   (clr),
        .dat_i   (dat),
        .oe_i    (oe),
        .bus_io  (bus),
        .rcv_o   (rcv)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic tx_edge();
        @(negedge clk); txclk = 1'b1;
        @(negedge clk); txclk = 1'b0;
        #1;
    endtask

    task automatic rx_edge();
        @(negedge clk); rxclk = 1'b1;
        @(negedge clk); rxclk = 1'b0;
        #1;
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        #1;
    endtask

    task automatic load_tx(input logic [W-1:0] v);
        ext_en = '0; oe = '1; dat = v;
        tx_edge();
    endtask

    task automatic t_reset();
        do_clear();
        oe = '1; ext_en = '0; settle();
        chk("R6 reset transmit bank", bus, '0);
        chk("R6 reset receive bank", rcv, '0);
    endtask

    task automatic t_tx_load();
        oe = '1; ext_en = '0; dat = 5'b10110;
        tx_edge();
        chk("R1 transmit load", bus, 5'b10110);
        chk("R3 driven bits", bus, 5'b10110);
        dat = 5'b01001; settle();
        chk("R1 no load without edge", bus, 5'b10110);
        tx_edge();
        chk("R1 second load", bus, 5'b01001);
    endtask

    task automatic t_rx_capture();
        oe = '0; ext_val = 5'b11010; ext_en = '1; settle();
        chk("R4 external value on bus", bus, 5'b11010);
        rx_edge();
        chk("R2 receive capture", rcv, 5'b11010);
        ext_val = 5'b00101; settle();
        chk("R2 no capture without edge", rcv, 5'b11010);
        rx_edge();
        chk("R4 external value captured", rcv, 5'b00101);
        ext_en = '0;
    endtask

    task automatic t_release();
        load_tx(5'b11111);
        oe = '0; ext_val = 5'b00000; ext_en = '1; settle();
        chk("R4 released bits not driven (ones held)", bus, 5'b00000);
        ext_en = '0;
        load_tx(5'b00000);
        oe = '0; ext_val = 5'b11111; ext_en = '1; settle();
        chk("R4 released bits not driven (zeros held)", bus, 5'b11111);
        ext_en = '0;
    endtask

    task automatic t_mixed();
        load_tx(5'b10101);
        oe = 5'b00111; ext_val = 5'b01000; ext_en = 5'b11000; settle();
        chk("R5 mixed drive", bus, 5'b01101);
        rx_edge();
        chk("R5 mixed capture", rcv, 5'b01101);
        ext_en = '0;
    endtask

    task automatic t_oe_toggle();
        load_tx(5'b11001);
        oe = '0; ext_val = 5'b00110; ext_en = '1; settle();
        chk("R8 released word", bus, 5'b00110);
        ext_en = '0; oe = '1; settle();
        chk("R8 re-enable shows unchanged register", bus, 5'b11001);
    endtask

    task automatic t_loopback();
        ext_en = '0; oe = '1; dat = 5'b10011;
        tx_edge();
        rx_edge();
        chk("R9 loopback", rcv, 5'b10011);
    endtask

    task automatic t_independent();
        dat = 5'b01100;
        tx_edge();
        chk("R10 transmit edge leaves receive bank", rcv, 5'b10011);
        chk("R10 transmit edge updates bus", bus, 5'b01100);
        dat = 5'b00001;
        rx_edge();
        chk("R10 receive edge leaves transmit bank", bus, 5'b01100);
        chk("R10 receive edge captures", rcv, 5'b01100);
    endtask

    task automatic t_async_clear();
        ext_en = '0; oe = '1; dat = 5'b11111;
        tx_edge(); rx_edge();
        chk("R6 setup before clear", rcv, 5'b11111);
        @(negedge clk); clr = 1'b1; #1;
        chk("R6 transmit cleared without edge", bus, '0);
        chk("R6 receive cleared without edge", rcv, '0);
        @(negedge clk); clr = 1'b0;
        dat = 5'b01010; settle();
        chk("R7 transmit waits for edge", bus, '0);
        chk("R7 receive waits for edge", rcv, '0);
        tx_edge();
        chk("R7 transmit loads after edge", bus, 5'b01010);
        chk("R7 receive still waits", rcv, '0);
        rx_edge();
        chk("R7 receive loads after edge", rcv, 5'b01010);
    endtask

    initial begin
        settle();
        t_reset();
        t_tx_load();
        t_rx_capture();
        t_release();
        t_mixed();
        t_oe_toggle();
        t_loopback();
        t_independent();
        t_async_clear();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule